// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is the architectural register store of a scalar datapath. It holds a set of general-purpose words and serves two operand reads and one result write in every clock cycle. This is enough to feed a two-operand ALU operation and retire its result in the same cycle.

Each read port takes a register number and returns that register's contents through its own selection multiplexer. The read is combinational from the stored state. The write port takes a register number, an enable and a data word. A one-hot decoder on the register number picks the single entry that is updated on the rising clock edge.

Entry zero is a constant-zero source: it always reads as zero, and writes aimed at it are discarded. A read of an entry in the same cycle as a write to that entry returns the value held before the edge.

Top module: `regfile_2r1w`

## Requirements
- R1: With default parameters the file holds 32 entries of 32 bits. The reset input is synchronous and active high. After a clock edge with reset high, every entry reads 0 on both ports.
- R2: When `wr_en` is 1 at a rising edge and `wr_addr` is not 0, the entry at `wr_addr` takes `wr_data`. From that edge on, the new value is visible on both read ports.
- R3: When `wr_en` is 0 at a rising edge, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R4: A write changes only the entry it addresses. Every other entry keeps its value.
- R5: Entry 0 reads as 0 at all times after reset. A write with `wr_addr` = 0 has no effect.
- R6: Each read port is combinational from the stored state and independent of the other port. Both ports return the same word when they carry the same address.
- R7: When an entry is read and written in the same cycle, the read returns the value held before the write edge until that edge occurs.
- R8: Reset takes priority over a write in the same cycle. The addressed entry reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Word to write |
| rd0_addr | input | 5 | Register number for read port 0 |
| rd0_data | output | 32 | Contents selected by read port 0 |
| rd1_addr | input | 5 | Register number for read port 1 |
| rd1_data | output | 32 | Contents selected by read port 1 |

## Verification
A read and a write can land on the same entry in one cycle. The bench provokes this by driving `wr_addr` equal to a read address with `wr_en` high, while the target still holds a different older value. It samples the read port in mid-cycle, before the rising edge, and expects the old word. It then reads the entry again after the edge and expects the new word. Reset arriving together with a write is provoked the same way, and is judged by reading the target back as zero.

// File: rtl/rf_pkg.sv
package rf_pkg;
   localparam int unsigned RF_DEF_ENTRIES = 32;
   localparam int unsigned RF_DEF_WIDTH   = 32;
   localparam int unsigned RF_NUM_RD      = 2;

   typedef enum logic {
      RF_ZERO_CONST    = 1'b0,
      RF_ZERO_WRITABLE = 1'b1
   } rf_zero_mode_e;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [ENTRIES-1:0] wr_sel
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
      assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
   end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
   import rf_pkg::*;
#(
   parameter int unsigned   ENTRIES   = 32,
   parameter int unsigned   DATA_W    = 32,
   parameter rf_zero_mode_e ZERO_MODE = RF_ZERO_CONST
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [ENTRIES-1:0]             wr_sel,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [ENTRIES-1:0][DATA_W-1:0] q
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      if (i == 0 && ZERO_MODE == RF_ZERO_CONST) begin : g_const
         // held at zero: any write attempt clears it again, so it folds to a constant
         always_ff @(posedge clk) begin
            if (rst || wr_sel[i]) q[i] <= '0;
         end
      end else begin : g_word
         always_ff @(posedge clk) begin
            if (rst)            q[i] <= '0;
            else if (wr_sel[i]) q[i] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic [ENTRIES-1:0][DATA_W-1:0] q,
   input  logic [ADDR_W-1:0]              addr,
   output logic [DATA_W-1:0]              data
);
   localparam bit FULL = (ENTRIES == (1 << ADDR_W));

   if (FULL) begin : g_full
      assign data = q[addr];
   end else begin : g_part
      always_comb begin
         data = '0;
         for (int k = 0; k < ENTRIES; k++) begin
            if (addr == ADDR_W'(k)) data = q[k];
         end
      end
   end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
   import rf_pkg::*;
#(
   parameter int unsigned   ENTRIES   = RF_DEF_ENTRIES,
   parameter int unsigned   DATA_W    = RF_DEF_WIDTH,
   parameter rf_zero_mode_e ZERO_MODE = RF_ZERO_CONST,
   localparam int unsigned  ADDR_W    = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd0_addr,
   output logic [DATA_W-1:0] rd0_data,
   input  logic [ADDR_W-1:0] rd1_addr,
   output logic [DATA_W-1:0] rd1_data
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("regfile_2r1w: ENTRIES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("regfile_2r1w: DATA_W must be positive");
   end

   logic [ENTRIES-1:0]             sel;
   logic [ENTRIES-1:0][DATA_W-1:0] q;
   logic [RF_NUM_RD-1:0][ADDR_W-1:0] ra;
   logic [RF_NUM_RD-1:0][DATA_W-1:0] rd;

   rf_wr_decode #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_sel  (sel)
   );

   rf_storage #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .ZERO_MODE(ZERO_MODE)) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (sel),
      .wr_data (wr_data),
      .q       (q)
   );

   assign ra[0] = rd0_addr;
   assign ra[1] = rd1_addr;

   for (genvar p = 0; p < RF_NUM_RD; p++) begin : g_rd
      rf_rd_mux #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
         .q    (q),
         .addr (ra[p]),
         .data (rd[p])
      );
   end

   assign rd0_data = rd[0];
   assign rd1_data = rd[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd0_addr,
   input logic [DATA_W-1:0] rd0_data,
   input logic [ADDR_W-1:0] rd1_addr,
   input logic [DATA_W-1:0] rd1_data
);
   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (rd0_data == '0 && rd1_data == '0)); // R1

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != '0) |=>
         (rd0_addr != $past(wr_addr) || rd0_data == $past(wr_data))); // R2

   AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_addr == rd1_addr) |=>
         (rd1_addr != $past(rd1_addr) || $stable(rd1_data))); // R4

   AST_ZERO_ENTRY: assert property (@(posedge clk) disable iff (rst)
      (rd0_addr == '0) |-> (rd0_data == '0)); // R5

   AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
      (rd0_addr == rd1_addr) |-> (rd0_data == rd1_data)); // R6
endmodule

bind regfile_2r1w rf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .rd0_addr (rd0_addr),
   .rd0_data (rd0_data),
   .rd1_addr (rd1_addr),
   .rd1_data (rd1_data)
);

// File: tb/regfile_2r1w_tb.sv
`timescale 1ns/1ps
module regfile_2r1w_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [4:0]  wr_addr;
   logic [31:0] wr_data;
   logic [4:0]  rd0_addr, rd1_addr;
   logic [31:0] rd0_data, rd1_data;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   regfile_2r1w u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd1_addr(rd1_addr), .rd1_data(rd1_data)
   );

   typedef struct packed {
      logic        we;
      logic [4:0]  wa;
      logic [31:0] wd;
      logic [4:0]  a0;
      logic [4:0]  a1;
      logic [31:0] e0;
      logic [31:0] e1;
   } vec_t;

   // expected values are the contents before this row's write edge
   localparam vec_t VECS [9] = '{
      '{1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd0,  32'h0,          32'h0},          // R7
      '{1'b1, 5'd6,  32'h1234_5678, 5'd5,  5'd6,  32'hA5A5_0001, 32'h0},          // R2
      '{1'b0, 5'd5,  32'hFFFF_FFFF, 5'd5,  5'd6,  32'hA5A5_0001, 32'h1234_5678}, // R2
      '{1'b0, 5'd7,  32'hDEAD_BEEF, 5'd5,  5'd7,  32'hA5A5_0001, 32'h0},          // R3
      '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd5,  32'h0,          32'hA5A5_0001}, // R5
      '{1'b1, 5'd31, 32'h8000_0001, 5'd0,  5'd31, 32'h0,          32'h0},          // R5
      '{1'b1, 5'd1,  32'h0000_00FF, 5'd31, 5'd31, 32'h8000_0001, 32'h8000_0001}, // R6
      '{1'b1, 5'd5,  32'h0,          5'd1,  5'd5,  32'h0000_00FF, 32'hA5A5_0001}, // R7
      '{1'b0, 5'd0,  32'h0,          5'd5,  5'd6,  32'h0,          32'h1234_5678}  // R4
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int r);
      return (32'(r) * 32'h0101_0101) ^ 32'hC3C3_0000;
   endfunction

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd0_addr = '0; rd1_addr = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state, every entry on both ports
      for (int r = 0; r < 32; r++) begin
         rd0_addr = 5'(r); rd1_addr = 5'(31 - r); #1;
         check("R1", rd0_data, 32'h0);
         check("R1", rd1_data, 32'h0);
      end
      // table walk
      for (int v = 0; v < 9; v++) begin
         @(negedge clk);
         wr_en = VECS[v].we; wr_addr = VECS[v].wa; wr_data = VECS[v].wd;
         rd0_addr = VECS[v].a0; rd1_addr = VECS[v].a1; #1;
         check("R2/R3/R5/R6/R7 table port0", rd0_data, VECS[v].e0);
         check("R2/R3/R5/R6/R7 table port1", rd1_data, VECS[v].e1);
      end
      // R7: new value visible after the edge
      @(negedge clk);
      wr_en = 1'b0; rd0_addr = 5'd5; rd1_addr = 5'd1; #1;
      check("R7 after edge", rd0_data, 32'h0);
      check("R2 after edge", rd1_data, 32'h0000_00FF);
      // R4: fill every entry, then read all back on both ports
      for (int r = 0; r < 32; r++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 5'(r); wr_data = pat(r);
      end
      @(negedge clk);
      wr_en = 1'b0;
      for (int r = 0; r < 32; r++) begin
         rd0_addr = 5'(r); rd1_addr = 5'(r); #1;
         check("R4 port0", rd0_data, (r == 0) ? 32'h0 : pat(r));
         check("R4 port1", rd1_data, (r == 0) ? 32'h0 : pat(r));
      end
      // R3: disabled write with live address and data
      wr_en = 1'b0; wr_addr = 5'd9; wr_data = 32'h5555_AAAA;
      @(negedge clk);
      rd0_addr = 5'd9; #1;
      check("R3 disabled write", rd0_data, pat(9));
      // R8: reset together with a write
      rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h7777_7777;
      @(negedge clk);
      rst = 1'b0; wr_en = 1'b0; rd0_addr = 5'd9; rd1_addr = 5'd20; #1;
      check("R8 reset over write", rd0_data, 32'h0);
      check("R1 cleared by reset", rd1_data, 32'h0);
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule